// File: doc/BRIEF.md
# Clock Forwarder Built on a Double-Data-Rate Output Stage

This block puts a copy of an internal clock onto an output pin without routing the clock net through logic. It drives a two-slot double-data-rate output stage with constant data pairs. The first slot is what the pin shows in the half period that starts at the source clock's active edge. The second slot is what it shows in the other half. The two slots hold a bit and its complement, so the pin toggles once per half period and has the same period as the source clock.

Gating does not use the output stage's own enable. That enable stays asserted at all times. When the block's enable is low, both data slots are loaded with one idle level, so the pin rests at that level. Parameters select the active edge of the source clock and of the forwarded clock. Optional parameters fix the idle level and the phase bit; when these are not given, defaults derived from the forwarded clock's active edge apply. The forwarded clock is meant only for the pin and is not used inside the design.

Top module: `clk_fwd_ddr`

## Requirements
- R1: With `en` high, `fwd_clk` has the same period as `clk_src`. It holds the phase bit for the half period that starts at the source active edge and the inverted phase bit for the other half.
- R2: With no phase given (`PHASE_GIVEN`=0), the active edge of `fwd_clk` falls on the active edge of `clk_src`. The phase bit is then 1 for a rising-active output (`OUT_FALLING`=0) and 0 for a falling-active output (`OUT_FALLING`=1). This holds for any combination of `SRC_FALLING` and `OUT_FALLING`.
- R3: With `PHASE_GIVEN`=1, `fwd_clk` carries `PHASE_LEVEL` in the half period after each source active edge and its complement in the other half.
- R4: `en` is sampled at each source active edge. A low sample makes `fwd_clk` sit at the idle level for the whole following source cycle. A high sample restarts the clock from that edge.
- R5: With no idle level given (`IDLE_GIVEN`=0), the idle level is 0 when `OUT_FALLING`=0 and 1 when `OUT_FALLING`=1.
- R6: With `IDLE_GIVEN`=1, the idle level is `IDLE_LEVEL`, whatever the active edges are.
- R7: `rst` is asynchronous and active high, and it acts only on the output stage. While it is high, both slots hold the idle level and `fwd_clk` stays at the idle level whatever `en` is. After release, the first source active edge loads the pair selected by `en`.
- R8: The output stage's own enable is always asserted, so a new data pair is captured at every source active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be forwarded |
| rst | input | 1 | Asynchronous active-high reset of the output stage |
| en | input | 1 | Forwarding enable, sampled at the source active edge |
| fwd_clk | output | 1 | Forwarded clock for the pin |

## Verification
The hardest case to reach is a falling-active source clock, because its stage samples `en` half a period apart from a rising-active stage that shares the same enable. The bench drives `en` just after a rising edge. It then samples the low half that follows at once, where only the falling-source instance has already gone idle, and the next high half, where the rising-source instances follow. Edge timestamps of the forwarded clocks, taken modulo the source period, confirm that output active edges line up with the source active edges in each edge combination.

// File: rtl/clk_fwd_ddr.sv
module clk_fwd_ddr #(
  parameter bit SRC_FALLING = 1'b0,
  parameter bit OUT_FALLING = 1'b0,
  parameter bit IDLE_GIVEN  = 1'b0,
  parameter bit IDLE_LEVEL  = 1'b0,
  parameter bit PHASE_GIVEN = 1'b0,
  parameter bit PHASE_LEVEL = 1'b0
) (
  input  logic clk_src,
  input  logic rst,
  input  logic en,
  output logic fwd_clk
);
  localparam bit IDLE_EFF  = IDLE_GIVEN  ? IDLE_LEVEL  : OUT_FALLING;
  localparam bit PHASE_EFF = PHASE_GIVEN ? PHASE_LEVEL : !OUT_FALLING;

  logic stage_en;
  logic d_first, d_second;
  logic q_first, q_second;

  assign stage_en = 1'b1;
  assign d_first  = en ? PHASE_EFF  : IDLE_EFF;
  assign d_second = en ? !PHASE_EFF : IDLE_EFF;

  generate
    if (SRC_FALLING) begin : g_fall
      always_ff @(negedge clk_src or posedge rst) begin
        if (rst) begin
          q_first  <= IDLE_EFF;
          q_second <= IDLE_EFF;
        end else if (stage_en) begin
          q_first  <= d_first;
          q_second <= d_second;
        end
      end
    end else begin : g_rise
      always_ff @(posedge clk_src or posedge rst) begin
        if (rst) begin
          q_first  <= IDLE_EFF;
          q_second <= IDLE_EFF;
        end else if (stage_en) begin
          q_first  <= d_first;
          q_second <= d_second;
        end
      end
    end
  endgenerate

  assign fwd_clk = (clk_src ^ SRC_FALLING) ? q_first : q_second;
endmodule

// File: rtl/clk_fwd_ddr_chk.sv
module clk_fwd_ddr_chk #(
  parameter bit SRC_FALLING = 1'b0,
  parameter bit IDLE_LVL    = 1'b0,
  parameter bit PHASE_LVL   = 1'b1
) (
  input logic clk_src,
  input logic rst,
  input logic en,
  input logic fwd_clk,
  input logic q_first,
  input logic q_second
);
  logic act_clk;
  assign act_clk = clk_src ^ SRC_FALLING;

  a_r3_pair_loaded: assert property (@(posedge act_clk) disable iff (rst)
    en |=> (q_first == PHASE_LVL && q_second == !PHASE_LVL));

  a_r4_idle_pair: assert property (@(posedge act_clk) disable iff (rst)
    !en |=> (q_first == IDLE_LVL && q_second == IDLE_LVL));

  a_r5_pin_idle: assert property (@(posedge act_clk) disable iff (rst)
    !en |=> fwd_clk == IDLE_LVL);

  a_r1_second_slot: assert property (@(posedge act_clk) disable iff (rst)
    (en && $past(en)) |-> fwd_clk == !PHASE_LVL);

  a_r7_reset_idle: assert property (@(posedge act_clk)
    rst |-> (q_first == IDLE_LVL && q_second == IDLE_LVL && fwd_clk == IDLE_LVL));
endmodule

bind clk_fwd_ddr clk_fwd_ddr_chk #(
  .SRC_FALLING(SRC_FALLING), .IDLE_LVL(IDLE_EFF), .PHASE_LVL(PHASE_EFF)
) chk_i (
  .clk_src(clk_src), .rst(rst), .en(en), .fwd_clk(fwd_clk),
  .q_first(q_first), .q_second(q_second)
);

// File: tb/clk_fwd_ddr_tb.sv
`timescale 1ns/1ps
module clk_fwd_ddr_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b0;
  logic en  = 1'b1;
  logic fo_i, fo_f, fo_x, fo_p;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  time t_rise_i = 0, t_prev_rise_i = 0, t_fall_x = 0, t_fall_f = 0;

  always #10 clk = ~clk;

  clk_fwd_ddr dut_i (.clk_src(clk), .rst(rst), .en(en), .fwd_clk(fo_i));
  clk_fwd_ddr #(.SRC_FALLING(1'b1), .OUT_FALLING(1'b1))
    dut_f (.clk_src(clk), .rst(rst), .en(en), .fwd_clk(fo_f));
  clk_fwd_ddr #(.OUT_FALLING(1'b1))
    dut_x (.clk_src(clk), .rst(rst), .en(en), .fwd_clk(fo_x));
  clk_fwd_ddr #(.PHASE_GIVEN(1'b1), .PHASE_LEVEL(1'b0), .IDLE_GIVEN(1'b1), .IDLE_LEVEL(1'b1))
    dut_p (.clk_src(clk), .rst(rst), .en(en), .fwd_clk(fo_p));

  always @(posedge fo_i) begin t_prev_rise_i = t_rise_i; t_rise_i = $time; end
  always @(negedge fo_x) t_fall_x = $time;
  always @(negedge fo_f) t_fall_f = $time;

  // entry: {en, high-half outputs {i,f,x,p}, low-half outputs {i,f,x,p}}
  localparam logic [8:0] VEC [8] = '{
    {1'b1, 4'b1100, 4'b0011}, {1'b0, 4'b0111, 4'b0111},
    {1'b0, 4'b0111, 4'b0111}, {1'b1, 4'b1100, 4'b0011},
    {1'b1, 4'b1100, 4'b0011}, {1'b0, 4'b0111, 4'b0111},
    {1'b1, 4'b1100, 4'b0011}, {1'b0, 4'b0111, 4'b0111}};

  task automatic chk(string req, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic chk_t(string req, time act, time exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual %0t expected %0t", req, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {fo_i, fo_f, fo_x, fo_p};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #1 rst = 1'b1;
    // R7: reset holds idle in both halves with en high
    @(posedge clk); #5 chk("R7 reset high half", outs(), 4'b0111);
    @(negedge clk); #5 chk("R7 reset low half", outs(), 4'b0111);
    @(posedge clk); #2 rst = 1'b0;

    // table walk: R1 R2 R3 R4 R5 R6 R8
    foreach (VEC[k]) begin
      @(posedge clk); #2 en = VEC[k][8];
      @(posedge clk); @(negedge clk);
      @(posedge clk); #5 chk(VEC[k][8] ? "R1 R2 R3 R8 high half" : "R4 R5 R6 high half", outs(), VEC[k][7:4]);
      @(negedge clk); #5 chk(VEC[k][8] ? "R1 R2 R3 R8 low half" : "R4 R5 R6 low half", outs(), VEC[k][3:0]);
    end

    // R4: disable timing for rising and falling source stages
    @(posedge clk); #2 en = 1'b1;
    repeat (2) @(posedge clk);
    #2 en = 1'b0;
    #3  chk("R4 rising source still running", {3'b000, fo_i}, 4'b0001);
    #10 chk("R4 falling source idle first", {3'b000, fo_f}, 4'b0001);
    #10 chk("R4 rising source idle next edge", {3'b000, fo_i}, 4'b0000);
    // R4 R8: re-enable restarts at next active edge
    @(posedge clk); #2 en = 1'b1;
    #13 chk("R4 R8 falling source resumes", {3'b000, fo_f}, 4'b0000);
    #10 chk("R4 R8 rising sources resume", {fo_i, 1'b0, fo_x, fo_p}, 4'b1000);

    // R1 R2: edge timing relative to source clock (posedge at 10+20k)
    repeat (3) @(posedge clk);
    #5;
    chk_t("R1 period", t_rise_i - t_prev_rise_i, 20);
    chk_t("R2 rising output on rising source edge", t_rise_i % 20, 10);
    chk_t("R2 falling output on rising source edge", t_fall_x % 20, 10);
    chk_t("R2 falling output on falling source edge", t_fall_f % 20, 0);

    // R7: mid-run reset, then recovery
    @(posedge clk); #2 rst = 1'b1;
    #3  chk("R7 mid-run reset high half", outs(), 4'b0111);
    #10 chk("R7 mid-run reset low half", outs(), 4'b0111);
    @(posedge clk); #2 rst = 1'b0;
    repeat (2) @(posedge clk);
    #5 chk("R7 recovery high half", outs(), 4'b1100);
    @(negedge clk); #5 chk("R7 recovery low half", outs(), 4'b0011);

    finish_run();
  end

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired actual running expected finished");
    finish_run();
  end
endmodule